// File: doc/BRIEF.md
# Dual-Channel Framed Sample Capture Buffer

The block takes samples from two parallel-output converters that share one sampling clock. On every cycle where the sample strobe is high during a capture frame, both channel values from that same edge are joined into one word and pushed into an on-chip buffer. The two channels are never taken in turns.

Capture works in frames. The host pulses an arm input while the buffer is empty, and the block starts storing. When the buffer fills, acquisition freezes and a level interrupt goes to the host. The host then empties the buffer with a run of reads. The interrupt drops when the last word leaves. The next frame starts only when the host arms again. Samples that arrive while the buffer is full are dropped and leave a sticky overflow flag behind.

Top module: `adc_pair_capture`

## Requirements
- R1: After reset, empty_o is 1, and full_o, irq_o, overflow_o, capturing_o and rd_data_o are all 0.
- R2: capturing_o rises on the edge after an arm_i pulse, and only when the block is idle with the buffer empty. Samples presented while not capturing are not stored.
- R3: A stored word holds channel A in bits 15:0 and channel B in bits 31:16. Both come from the same strobed cycle.
- R4: Reads return stored words in arrival order. rd_data_o is updated on the edge that accepts rd_en_i and holds its value between reads.
- R5: full_o goes high on the edge of the write that fills the buffer. On the next edge capturing_o drops and irq_o rises.
- R6: A strobe while full_o is high stores nothing and sets overflow_o. overflow_o stays set until the next accepted arm clears it.
- R7: irq_o stays high while frozen words remain, and falls in the cycle empty_o rises after the last read.
- R8: A read while empty_o is high returns 0 and does not move the read pointer. The first word of the next frame is still read back correctly.
- R9: arm_i while frozen or draining has no effect. capturing_o stays 0.
- R10: A cycle with sample_vld_i low stores nothing, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling and host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_a_i | input | 16 | Channel A sample |
| ch_b_i | input | 16 | Channel B sample |
| sample_vld_i | input | 1 | Both samples valid this cycle |
| arm_i | input | 1 | Start-of-frame pulse from host |
| rd_en_i | input | 1 | Host read strobe |
| rd_data_o | output | 32 | Read word, {B, A} |
| full_o | output | 1 | Buffer full (registered) |
| empty_o | output | 1 | Buffer empty (registered) |
| overflow_o | output | 1 | Sticky: sample lost while full |
| capturing_o | output | 1 | Frame capture in progress |
| irq_o | output | 1 | Host interrupt, level |

## Verification
A bad occupancy count shows at the ports at once. full_o or empty_o flips on the wrong edge, and irq_o is then wrong one cycle later. A read or write pointer that slips shows up as a wrong word on the next read, and a lost or repeated word surfaces by the end of the drain. A stuck frame state shows as capturing_o or irq_o disagreeing with the bench model, either on the cycle after an arm or on the cycle after the buffer fills or empties.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAPT  = 2'd1,
    ST_DRAIN = 2'd2
  } cap_state_e;
endpackage

// File: rtl/cap_pack.sv
module cap_pack #(
  parameter int SAMPLE_W = 16,
  parameter int NCH      = 2,
  localparam int WORD_W  = SAMPLE_W * NCH
) (
  input  logic [NCH*SAMPLE_W-1:0] ch_flat_i,
  output logic [WORD_W-1:0]       word_o
);
  // channel k lands in slice k of the word
  for (genvar k = 0; k < NCH; k++) begin : g_lane
    assign word_o[k*SAMPLE_W +: SAMPLE_W] = ch_flat_i[k*SAMPLE_W +: SAMPLE_W];
  end
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 1024,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    count_q, count_d;
  logic             full_q, empty_q;
  logic             wr_ok, rd_ok;

  assign wr_ok = wr_i && !full_q;
  assign rd_ok = rd_i && !empty_q;

  always_comb begin
    count_d = count_q;
    if (wr_ok && !rd_ok)      count_d = count_q + CW'(1);
    else if (rd_ok && !wr_ok) count_d = count_q - CW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      count_q   <= '0;
      full_q    <= 1'b0;
      empty_q   <= 1'b1;
      rd_data_o <= '0;
    end else begin
      if (wr_ok) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + AW'(1);
      if (rd_ok) rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + AW'(1);
      if (rd_i)  rd_data_o <= rd_ok ? mem_q[rd_ptr_q] : '0;
      count_q <= count_d;
      full_q  <= (count_d == CNT_FULL);
      empty_q <= (count_d == '0);
    end
  end

  assign full_o  = full_q;
  assign empty_o = empty_q;

  // R8
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && empty_o |=> rd_data_o == '0);

  // R6
  full_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !rd_i |=> full_o && $stable(wr_ptr_q));

  // R4
  idle_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && !rd_i |=> $stable(count_q) && $stable(rd_data_o));
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import adc_cap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_vld_i,
  input  logic arm_i,
  input  logic rd_i,
  input  logic full_i,
  input  logic empty_i,
  output logic wr_o,
  output logic overflow_o,
  output logic capturing_o,
  output logic irq_o
);
  cap_state_e state_q, state_d;
  logic       ovf_q;
  logic       arm_ok;

  assign arm_ok = arm_i && (state_q == ST_IDLE) && empty_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (arm_ok)  state_d = ST_CAPT;
      ST_CAPT:  if (full_i)  state_d = ST_DRAIN;
      ST_DRAIN: if (empty_i) state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (arm_ok)                     ovf_q <= 1'b0;
      else if (sample_vld_i && full_i) ovf_q <= 1'b1;
    end
  end

  assign wr_o        = sample_vld_i && (state_q == ST_CAPT);
  assign overflow_o  = ovf_q;
  assign capturing_o = (state_q == ST_CAPT);
  assign irq_o       = (state_q == ST_DRAIN) && !empty_i;

  // R5
  irq_after_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capturing_o && full_i |=> irq_o && !capturing_o);

  // R7
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !rd_i |=> irq_o);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !arm_i |=> overflow_o);

  // R9
  arm_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i && irq_o |=> !capturing_o);
endmodule

// File: rtl/adc_pair_capture.sv
module adc_pair_capture #(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 1024,
  localparam int NCH     = 2,
  localparam int WORD_W  = SAMPLE_W * NCH
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] ch_a_i,
  input  logic [SAMPLE_W-1:0] ch_b_i,
  input  logic                sample_vld_i,
  input  logic                arm_i,
  input  logic                rd_en_i,
  output logic [WORD_W-1:0]   rd_data_o,
  output logic                full_o,
  output logic                empty_o,
  output logic                overflow_o,
  output logic                capturing_o,
  output logic                irq_o
);
  logic [WORD_W-1:0] word;
  logic              wr;

  cap_pack #(.SAMPLE_W(SAMPLE_W), .NCH(NCH)) u_pack (
    .ch_flat_i ({ch_b_i, ch_a_i}),
    .word_o    (word)
  );

  cap_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sample_vld_i (sample_vld_i),
    .arm_i        (arm_i),
    .rd_i         (rd_en_i),
    .full_i       (full_o),
    .empty_i      (empty_o),
    .wr_o         (wr),
    .overflow_o   (overflow_o),
    .capturing_o  (capturing_o),
    .irq_o        (irq_o)
  );

  cap_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .wr_data_i (word),
    .rd_i      (rd_en_i),
    .rd_data_o (rd_data_o),
    .full_o    (full_o),
    .empty_o   (empty_o)
  );

  // R2
  idle_no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capturing_o && empty_o && !arm_i |=> empty_o);
endmodule

// File: tb/adc_pair_capture_tb.sv
module adc_pair_capture_tb;
  localparam int DEPTH = 16;
  localparam int ST_IDLE = 0, ST_CAPT = 1, ST_DRAIN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ch_a = '0, ch_b = '0;
  logic        vld = 1'b0, arm = 1'b0, rd = 1'b0;
  logic [31:0] dout;
  logic        full, empty, ovf, capt, irq;

  always #5 clk = ~clk;

  adc_pair_capture #(.SAMPLE_W(16), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ch_a_i(ch_a), .ch_b_i(ch_b),
    .sample_vld_i(vld), .arm_i(arm), .rd_en_i(rd), .rd_data_o(dout),
    .full_o(full), .empty_o(empty), .overflow_o(ovf),
    .capturing_o(capt), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0;
  logic [31:0] q [$];
  int          m_st = ST_IDLE;
  logic        m_ovf = 1'b0;
  logic [31:0] m_rd = '0;
  string       m_rd_tag = "R4";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void model_step(input logic v, input logic [15:0] a, input logic [15:0] b,
                                     input logic ar, input logic r);
    int  sz  = q.size();
    logic f  = (sz == DEPTH);
    logic e  = (sz == 0);
    logic ok = ar && (m_st == ST_IDLE) && e;
    if (r) begin
      if (!e) begin m_rd = q.pop_front(); m_rd_tag = "R4"; end
      else    begin m_rd = '0;            m_rd_tag = "R8"; end
    end
    if (v && m_st == ST_CAPT && !f) q.push_back({b, a});
    if (ok)          m_ovf = 1'b0;
    else if (v && f) m_ovf = 1'b1;
    case (m_st)
      ST_IDLE:  if (ok) m_st = ST_CAPT;
      ST_CAPT:  if (f)  m_st = ST_DRAIN;
      default:  if (e)  m_st = ST_IDLE;
    endcase
  endfunction

  task automatic compare_all();
    chk("R5 full",  32'(full), 32'(q.size() == DEPTH));
    chk("R5 empty", 32'(empty), 32'(q.size() == 0));
    chk("R7 irq",   32'(irq),  32'(m_st == ST_DRAIN && q.size() != 0));
    chk("R6 ovf",   32'(ovf),  32'(m_ovf));
    chk("R2 capt",  32'(capt), 32'(m_st == ST_CAPT));
    chk({m_rd_tag, " rd_data"}, dout, m_rd);
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input logic v, input logic [15:0] a, input logic [15:0] b,
                     input logic ar, input logic r);
    vld = v; ch_a = a; ch_b = b; arm = ar; rd = r;
    @(posedge clk);
    model_step(v, a, b, ar, r);
    @(negedge clk);
    compare_all();
    vld = 1'b0; arm = 1'b0; rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", 32'(empty), 32'd1);
    chk("R1 full",  32'(full),  32'd0);
    chk("R1 irq",   32'(irq),   32'd0);
    chk("R1 ovf",   32'(ovf),   32'd0);
    chk("R1 capt",  32'(capt),  32'd0);
    chk("R1 data",  dout,       32'd0);

    // R2: samples while idle are dropped
    for (int i = 0; i < 3; i++) cyc(1'b1, 16'(i + 7), 16'hbeef, 1'b0, 1'b0);
    chk("R2 idle drop", 32'(empty), 32'd1);

    cyc(1'b0, '0, '0, 1'b1, 1'b0);
    chk("R2 armed", 32'(capt), 32'd1);

    // R10: strobe low stores nothing
    for (int i = 0; i < 3; i++) cyc(1'b0, 16'hffff, 16'h5555, 1'b0, 1'b0);
    chk("R10 no strobe", 32'(empty), 32'd1);

    // R3: lane placement
    cyc(1'b1, 16'h1234, 16'habcd, 1'b0, 1'b0);
    cyc(1'b0, '0, '0, 1'b0, 1'b1);
    chk("R3 packing", dout, 32'habcd_1234);

    // fill with gaps
    while (!full) cyc(1'($urandom_range(0, 3) != 0), 16'($urandom), 16'($urandom), 1'b0, 1'b0);
    chk("R5 full seen", 32'(full), 32'd1);
    // R6: strobe during freeze cycle while full
    cyc(1'b1, 16'h0bad, 16'h0bad, 1'b0, 1'b0);
    chk("R6 overflow set", 32'(ovf), 32'd1);
    chk("R5 irq up", 32'(irq), 32'd1);
    chk("R5 capt down", 32'(capt), 32'd0);

    // R9: arm while draining is ignored
    cyc(1'b0, '0, '0, 1'b1, 1'b0);
    cyc(1'b0, '0, '0, 1'b0, 1'b0);
    chk("R9 arm ignored", 32'(capt), 32'd0);
    chk("R9 irq kept", 32'(irq), 32'd1);

    // drain with gaps
    while (!empty) cyc(1'b1, 16'($urandom), 16'($urandom), 1'b0, 1'($urandom_range(0, 2) != 0));
    chk("R7 irq low at empty", 32'(irq), 32'd0);
    // R8: reads on empty return zero
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, '0, '0, 1'b0, 1'b1);
      chk("R8 empty read", dout, 32'd0);
    end

    cyc(1'b0, '0, '0, 1'b1, 1'b0);
    chk("R6 cleared on arm", 32'(ovf), 32'd0);
    cyc(1'b1, 16'h7777, 16'h2222, 1'b0, 1'b0);
    cyc(1'b0, '0, '0, 1'b0, 1'b1);
    chk("R8 pointer kept", dout, 32'h2222_7777);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic r_v  = 1'($urandom_range(0, 9) < 6);
      logic r_ar = 1'($urandom_range(0, 19) == 0);
      logic r_rd = (m_st == ST_DRAIN) ? 1'($urandom_range(0, 9) < 7)
                                      : 1'($urandom_range(0, 9) < 2);
      cyc(r_v, 16'($urandom), 16'($urandom), r_ar, r_rd);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule